// File: doc/BRIEF.md
# Split Serial Access Register

This block is the serial side of a dual-ported video memory. It holds one row of words that a serial port reads out (or fills in) one word per serial clock tick, independently of whatever the random-access array is doing. A parallel transfer port moves a complete row between the array and the register in either direction. The same transfer also sets the tap, which is the word where streaming begins. Any of the word locations may be chosen.

In split operation the register is treated as two halves. A split transfer refills only the half that is not being streamed, and it records a start offset for that half. When the stream runs off the end of the active half, it continues in the other half at the recorded offset, with no gap. A status output shows which half holds the serial pointer. The serial data output is driven only while serial enable is high and the port is in read direction. Otherwise its enable is low and the pin is left undriven.

Top module: `split_sam`

## Requirements
- R1: After reset the serial pointer is at word 0, the half status is 0, the transfer acknowledge is low, and the register is in full (non-split) mode.
- R2: A transfer request with `xfer_dir`=0 and `xfer_split`=0 loads every word `i` from `row_in[i*W +: W]`, moves the pointer to `xfer_tap`, and selects full mode. All of this takes effect at the same clock edge.
- R3: A transfer request with `xfer_dir`=1 is a write-back, whatever the value of `xfer_split`. Word `i` is always visible on `row_out[i*W +: W]`, and the register contents are left unchanged. The pointer moves to `xfer_tap` and full mode is selected.
- R4: In full mode, each `sc_tick` with no transfer request advances the pointer by one, and the pointer wraps from DEPTH-1 to 0. Without a tick or a request, the pointer holds.
- R5: `sdq_oe` is 1 exactly when `se`=1 and `wr_mode`=0. While `sdq_oe` is 1, `sdq_o` is the word at the pointer.
- R6: A tick with `se`=1 and `wr_mode`=1 stores `sdq_i` into the word at the pointer, and then the pointer advances as for any other tick.
- R7: A split load (`xfer_req`=1, `xfer_split`=1, `xfer_dir`=0) loads only the half that does not contain the pointer. It leaves the other half and the pointer unchanged. It stores `xfer_tap` without its top bit as the pending offset, and it selects split mode.
- R8: In split mode, a tick while the pointer is on the last word of a half moves the pointer to the other half, at the pending offset.
- R9: `half_sel` equals the top bit of the pointer, so it toggles at every split crossing.
- R10: `xfer_ack` is high for one cycle in the cycle after each transfer request.
- R11: A tick in the same cycle as a full or write-back transfer has no effect. A tick in the same cycle as a split load is applied, and a crossing in that cycle uses the new pending offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sc_tick | input | 1 | Serial clock tick, one word step |
| se | input | 1 | Serial port enable |
| wr_mode | input | 1 | Serial direction: 1 writes, 0 reads |
| sdq_i | input | W | Serial write data |
| sdq_o | output | W | Serial read data |
| sdq_oe | output | 1 | Output enable for the serial data pins |
| half_sel | output | 1 | Half that holds the serial pointer |
| xfer_req | input | 1 | Transfer request, one cycle |
| xfer_dir | input | 1 | 0 loads from the array, 1 writes back to it |
| xfer_split | input | 1 | Split load of the inactive half |
| xfer_tap | input | AW | Start tap, or pending offset for a split load |
| row_in | input | DEPTH*W | Row data from the array |
| row_out | output | DEPTH*W | Register contents toward the array |
| xfer_ack | output | 1 | Transfer acknowledge |

## Verification
The hardest case to reach is a split load that lands in the same cycle as the tick that crosses out of the active half. In that cycle the new pending offset and the new mode must steer the jump, while the active half must stay untouched. The bench uses a 16-word configuration. It sweeps every pending offset and places a concurrent tick on the split load in alternate runs. For runs where the pointer is already on the boundary word, it parks the pointer there on purpose so that the load and the crossing coincide. A full write-back after each run compares both halves against a bench model.

// File: rtl/split_sam.sv
module split_sam #(
  parameter int DEPTH = 512,
  parameter int W = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int HW = AW - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sc_tick,
  input  logic               se,
  input  logic               wr_mode,
  input  logic [W-1:0]       sdq_i,
  output logic [W-1:0]       sdq_o,
  output logic               sdq_oe,
  output logic               half_sel,
  input  logic               xfer_req,
  input  logic               xfer_dir,
  input  logic               xfer_split,
  input  logic [AW-1:0]      xfer_tap,
  input  logic [DEPTH*W-1:0] row_in,
  output logic [DEPTH*W-1:0] row_out,
  output logic               xfer_ack
);
  localparam int HALF = DEPTH / 2;

  logic [AW-1:0] ptr, ptr_adv, ptr_nx;
  logic [HW-1:0] pend, pend_nx;
  logic          split_mode, mode_nx;
  logic          full_xfer, split_ld, ser_wr, at_end;

  assign full_xfer = xfer_req & (~xfer_split | xfer_dir);
  assign split_ld  = xfer_req & xfer_split & ~xfer_dir;
  assign ser_wr    = sc_tick & se & wr_mode & ~full_xfer;
  assign at_end    = &ptr[HW-1:0];

  assign mode_nx = full_xfer ? 1'b0 : (split_ld ? 1'b1 : split_mode);
  assign pend_nx = split_ld ? xfer_tap[HW-1:0] : pend;
  assign ptr_adv = (mode_nx && at_end) ? {~ptr[AW-1], pend_nx} : ptr + AW'(1);
  assign ptr_nx  = full_xfer ? xfer_tap : (sc_tick ? ptr_adv : ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      pend       <= '0;
      split_mode <= 1'b0;
      xfer_ack   <= 1'b0;
    end else begin
      ptr        <= ptr_nx;
      pend       <= pend_nx;
      split_mode <= mode_nx;
      xfer_ack   <= xfer_req;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam bit UPPER = (i >= HALF);
    logic [W-1:0] word_q;
    logic         ld, wr;
    assign ld = (full_xfer & ~xfer_dir) | (split_ld & (UPPER != ptr[AW-1]));
    assign wr = ser_wr & (ptr == AW'(i));
    always_ff @(posedge clk) begin
      if (ld)      word_q <= row_in[i*W +: W];
      else if (wr) word_q <= sdq_i;
    end
    assign row_out[i*W +: W] = word_q;
  end

  assign sdq_oe   = se & ~wr_mode;
  assign sdq_o    = sdq_oe ? row_out[ptr*W +: W] : '0;
  assign half_sel = ptr[AW-1];

  assert_reset_ptr_R1: assert property (@(posedge clk)
    rst |=> (ptr == '0 && !split_mode && !xfer_ack));

  assert_tap_load_R2: assert property (@(posedge clk) disable iff (rst)
    full_xfer |=> (ptr == $past(xfer_tap) && !split_mode));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (sc_tick && !xfer_req && !split_mode) |=> (ptr == $past(ptr) + AW'(1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!sc_tick && !xfer_req) |=> $stable(ptr));

  assert_split_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (split_ld && !sc_tick) |=> ($stable(ptr) && split_mode));

  assert_cross_R8: assert property (@(posedge clk) disable iff (rst)
    (sc_tick && !xfer_req && split_mode && at_end) |=> (half_sel != $past(half_sel)));

  assert_ack_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> $past(xfer_req));

  assert_full_tick_R11: assert property (@(posedge clk) disable iff (rst)
    (full_xfer && sc_tick) |=> (ptr == $past(xfer_tap)));
endmodule

// File: tb/split_sam_tb.sv
module split_sam_tb_top;
  localparam int D = 16;
  localparam int W = 4;
  localparam int AW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sc_tick = 0, se = 0, wr_mode = 0, xfer_req = 0, xfer_dir = 0, xfer_split = 0;
  logic [W-1:0] sdq_i = '0, sdq_o;
  logic sdq_oe, half_sel, xfer_ack;
  logic [AW-1:0] xfer_tap = '0;
  logic [D*W-1:0] row_in = '0, row_out;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [W-1:0] mm [D];
  int mp = 0, mpend = 0;
  bit msplit = 0;

  always #2.5 clk = ~clk;

  split_sam #(.DEPTH(D), .W(W)) dut_i (
    .clk(clk), .rst(rst), .sc_tick(sc_tick), .se(se), .wr_mode(wr_mode),
    .sdq_i(sdq_i), .sdq_o(sdq_o), .sdq_oe(sdq_oe), .half_sel(half_sel),
    .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_split(xfer_split),
    .xfer_tap(xfer_tap), .row_in(row_in), .row_out(row_out), .xfer_ack(xfer_ack));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [D*W-1:0] pat(input int seed, input int mul);
    logic [D*W-1:0] r;
    for (int i = 0; i < D; i++) r[i*W +: W] = W'(i * mul + seed);
    return r;
  endfunction

  task automatic cyc(input bit req, input bit dir, input bit spl, input int tap,
                     input bit tick, input bit s_e, input bit wr,
                     input logic [W-1:0] din, input logic [D*W-1:0] row, input string tag);
    int oldp;
    xfer_req = req; xfer_dir = dir; xfer_split = spl; xfer_tap = AW'(tap);
    sc_tick = tick; se = s_e; wr_mode = wr; sdq_i = din; row_in = row;
    oldp = mp;
    if (req && (!spl || dir)) begin
      if (!dir) for (int i = 0; i < D; i++) mm[i] = row[i*W +: W];
      mp = tap; msplit = 0;
    end else begin
      if (req) begin
        for (int i = 0; i < D; i++) if ((i / (D/2)) != (oldp / (D/2))) mm[i] = row[i*W +: W];
        mpend = tap % (D/2); msplit = 1;
      end
      if (tick) begin
        if (s_e && wr) mm[oldp] = din;
        if (msplit && (oldp % (D/2)) == (D/2 - 1)) mp = (oldp < D/2 ? D/2 : 0) + mpend;
        else mp = (oldp + 1) % D;
      end
    end
    @(posedge clk); #1;
    xfer_req = 0; sc_tick = 0;
    chk(xfer_ack == req, "R10 ack", int'(xfer_ack), int'(req));
    chk(half_sel == (mp >= D/2), "R9 half_sel", int'(half_sel), int'(mp >= D/2));
    chk(sdq_oe == (s_e && !wr), "R5 oe", int'(sdq_oe), int'(s_e && !wr));
    if (s_e && !wr) chk(sdq_o == mm[mp], tag, int'(sdq_o), int'(mm[mp]));
  endtask

  task automatic cmp_row(input string tag);
    for (int i = 0; i < D; i++)
      chk(row_out[i*W +: W] == mm[i], tag, int'(row_out[i*W +: W]), int'(mm[i]));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk(half_sel == 0, "R1 half_sel", int'(half_sel), 0);
    chk(xfer_ack == 0, "R1 ack", int'(xfer_ack), 0);
    chk(sdq_oe == 0, "R1 oe", int'(sdq_oe), 0);

    // R1: pointer starts at word 0, seen through a serial write and a write-back
    mp = 0;
    cyc(0, 0, 0, 0, 1, 1, 1, 4'hA, '0, "R1");
    cyc(1, 1, 0, 0, 0, 1, 1, 4'h0, '0, "R1");
    chk(row_out[3:0] == 4'hA, "R1 word0", int'(row_out[3:0]), 10);

    // R2 and R4: every tap, stream past the wrap point
    for (int t = 0; t < D; t++) begin
      cyc(1, 0, 0, t, 0, 1, 0, 0, pat(t, 5), "R2 tap load");
      for (int k = 0; k <= D; k++) cyc(0, 0, 0, 0, 1, 1, 0, 0, '0, "R4 stream");
    end

    // R11: a tick in the same cycle as a full load is dropped
    cyc(1, 0, 0, 6, 1, 1, 0, 0, pat(3, 7), "R11 full+tick");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, '0, "R4 hold");

    // R5: output enable combinations
    cyc(0, 0, 0, 0, 0, 0, 0, 0, '0, "R5");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, '0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, '0, "R5");

    // R6 and R3: serial write of a full row, then write-back and read back
    cyc(1, 0, 0, 3, 0, 1, 1, 0, '0, "R6");
    for (int k = 0; k < D; k++) cyc(0, 0, 0, 0, 1, 1, 1, W'(k * 3 + 1), '0, "R6");
    cyc(1, 1, 1, 0, 0, 1, 0, 0, pat(9, 1), "R3 write-back");
    cmp_row("R3 row_out");
    for (int k = 0; k < D; k++) cyc(0, 0, 0, 0, 1, 1, 0, 0, '0, "R6 readback");

    // R7, R8, R11: split loads for every pending offset
    for (int t2 = 0; t2 < D/2; t2++) begin
      cyc(1, 0, 0, 2, 0, 1, 0, 0, pat(0, 5), "R2");
      // park on the last word of the lower half for some runs so load and crossing coincide
      if (t2 % 4 == 3) for (int k = 0; k < D/2 - 3; k++) cyc(0, 0, 0, 0, 1, 1, 0, 0, '0, "R4");
      cyc(1, 0, 1, t2 + D/2, t2 % 2, 1, 0, 0, pat(9, 3), "R7 split load");
      for (int k = 0; k < 2 * D; k++) cyc(0, 0, 0, 0, 1, 1, 0, 0, '0, "R8 split stream");
      cyc(1, 1, 0, 0, 0, 1, 0, 0, '0, "R3");
      cmp_row("R7 halves");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule